// File: doc/BRIEF.md
# Shared-Offset Dual Message Buffer

This block holds the two byte buffers through which a host processor and a management controller exchange messages. The host sees a small window of four byte addresses, decoded from a 2-bit offset. Offset 1 is shared by both buffers. A host write there pushes a byte into the host-to-controller buffer, and a host read there pops a byte from the controller-to-host buffer. Offsets 0 and 2 belong to neighbouring control and mask registers. The block forwards their read data and raises write selects for them. Offset 3 is unused.

The management controller has its own byte port. It pops the host-to-controller buffer and pushes the controller-to-host buffer. Each buffer has its own write and read counters. Either counter can be returned to the buffer start by a one-cycle clear strobe from the control register. This lets a message be rewritten from the beginning, or read again from its first byte. Each buffer holds 64 bytes by default, and its counters address the storage modulo the depth.

Top module: `msgbuf_pair`

## Requirements
- R1: Host offset decode: a host read of offset 0 returns `ctrl_rdata`, offset 2 returns `mask_rdata`, and offset 3 returns 0. In the same cycle as the write, `ctrl_wr_sel` is high exactly for host writes to offset 0 and `mask_wr_sel` exactly for host writes to offset 2. A host write to offset 3 raises no select and changes no buffer.
- R2: A host write to offset 1 appends `host_wdata` to the host-to-controller buffer. Controller reads return these bytes in the order they were written.
- R3: A controller write appends `mc_wdata` to the controller-to-host buffer. Host reads of offset 1 return these bytes in the order they were written.
- R4: Each buffer accepts at most DEPTH (64) bytes after its write counter was last cleared. Further writes are dropped.
- R5: A read of a buffer that holds no unread byte returns 0 and does not advance the read counter.
- R6: A host clear-write strobe (`host_clr_h2c_wr`) restarts host-to-controller filling at the buffer start. A controller clear-read strobe (`mc_clr_h2c_rd`) makes the next controller read return the buffer's first byte.
- R7: A controller clear-write strobe (`mc_clr_c2h_wr`) restarts controller-to-host filling at the buffer start. A host clear-read strobe (`host_clr_c2h_rd`) makes the next host read of offset 1 return the buffer's first byte.
- R8: A clear strobe in the same cycle as an access to the counter it clears wins. A write is dropped. A read returns 0 and leaves the read counter at the start.
- R9: After reset both buffers are empty and both read-data outputs are 0.
- R10: Read data appears on the clock edge that takes the read and holds its value until the next read on that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 2 | Host byte offset within the window |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, registered |
| ctrl_rdata | input | 8 | Read value of the neighbouring control register |
| mask_rdata | input | 8 | Read value of the neighbouring mask register |
| ctrl_wr_sel | output | 1 | Host write to offset 0 this cycle |
| mask_wr_sel | output | 1 | Host write to offset 2 this cycle |
| host_clr_h2c_wr | input | 1 | Clear strobe for the host-to-controller write counter |
| host_clr_c2h_rd | input | 1 | Clear strobe for the controller-to-host read counter |
| mc_wr | input | 1 | Controller write strobe (pushes controller-to-host) |
| mc_wdata | input | 8 | Controller write data |
| mc_rd | input | 1 | Controller read strobe (pops host-to-controller) |
| mc_rdata | output | 8 | Controller read data, registered |
| mc_clr_c2h_wr | input | 1 | Clear strobe for the controller-to-host write counter |
| mc_clr_h2c_rd | input | 1 | Clear strobe for the host-to-controller read counter |

## Verification
The write selects are combinational, so the bench checks them in the same cycle it drives the write. Every other result arrives on the first rising edge after the stimulus. Writes become visible to the opposite port's read in the following cycle, and read data is registered on the edge that takes the read. The bench drives inputs on the falling edge and samples on the next falling edge, exactly one register stage later. It also samples once more after an idle cycle to confirm that the read data holds.

// File: rtl/msgbuf_pair.sv
module msgbuf_pair #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [DATA_W-1:0] ctrl_rdata,
  input  logic [DATA_W-1:0] mask_rdata,
  output logic              ctrl_wr_sel,
  output logic              mask_wr_sel,
  input  logic              host_clr_h2c_wr,
  input  logic              host_clr_c2h_rd,
  input  logic              mc_wr,
  input  logic [DATA_W-1:0] mc_wdata,
  input  logic              mc_rd,
  output logic [DATA_W-1:0] mc_rdata,
  input  logic              mc_clr_c2h_wr,
  input  logic              mc_clr_h2c_rd
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] h2c_mem [DEPTH];
  logic [DATA_W-1:0] c2h_mem [DEPTH];
  logic [CNT_W-1:0]  h2c_wcnt, h2c_rcnt, c2h_wcnt, c2h_rcnt;

  wire buf_sel   = host_addr == 2'd1;
  wire h2c_avail = h2c_rcnt < h2c_wcnt;
  wire c2h_avail = c2h_rcnt < c2h_wcnt;
  wire h2c_push  = host_wr && buf_sel && (h2c_wcnt < FULL) && !host_clr_h2c_wr;
  wire c2h_push  = mc_wr && (c2h_wcnt < FULL) && !mc_clr_c2h_wr;
  wire h2c_pop   = mc_rd && h2c_avail && !mc_clr_h2c_rd;
  wire c2h_pop   = host_rd && buf_sel && c2h_avail && !host_clr_c2h_rd;

  assign ctrl_wr_sel = host_wr && (host_addr == 2'd0);
  assign mask_wr_sel = host_wr && (host_addr == 2'd2);

  always_ff @(posedge clk) begin
    if (h2c_push) h2c_mem[h2c_wcnt[PTR_W-1:0]] <= host_wdata;
    if (c2h_push) c2h_mem[c2h_wcnt[PTR_W-1:0]] <= mc_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h2c_wcnt <= '0;
      h2c_rcnt <= '0;
      c2h_wcnt <= '0;
      c2h_rcnt <= '0;
    end else begin
      if (host_clr_h2c_wr)   h2c_wcnt <= '0;
      else if (h2c_push)     h2c_wcnt <= h2c_wcnt + 1'b1;
      if (mc_clr_h2c_rd)     h2c_rcnt <= '0;
      else if (h2c_pop)      h2c_rcnt <= h2c_rcnt + 1'b1;
      if (mc_clr_c2h_wr)     c2h_wcnt <= '0;
      else if (c2h_push)     c2h_wcnt <= c2h_wcnt + 1'b1;
      if (host_clr_c2h_rd)   c2h_rcnt <= '0;
      else if (c2h_pop)      c2h_rcnt <= c2h_rcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      unique case (host_addr)
        2'd0:    host_rdata <= ctrl_rdata;
        2'd1:    host_rdata <= c2h_pop ? c2h_mem[c2h_rcnt[PTR_W-1:0]] : '0;
        2'd2:    host_rdata <= mask_rdata;
        default: host_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mc_rdata <= '0;
    else if (mc_rd) mc_rdata <= h2c_pop ? h2c_mem[h2c_rcnt[PTR_W-1:0]] : '0;
  end

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (h2c_wcnt == FULL && !host_clr_h2c_wr) |=> $stable(h2c_wcnt));
  a_r4_c2h_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (c2h_wcnt == FULL && !mc_clr_c2h_wr) |=> $stable(c2h_wcnt));
  a_r5_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_rd && h2c_rcnt >= h2c_wcnt && !mc_clr_h2c_rd) |=> (mc_rdata == '0 && $stable(h2c_rcnt)));
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && buf_sel && host_clr_c2h_rd) |=> (host_rdata == '0 && c2h_rcnt == '0));
  a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 2'd3) |=> host_rdata == '0);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));
endmodule

// File: tb/msgbuf_pair_bench.sv
module msgbuf_pair_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] host_addr = '0;
  logic host_wr = 0, host_rd = 0, host_clr_h2c_wr = 0, host_clr_c2h_rd = 0;
  logic mc_wr = 0, mc_rd = 0, mc_clr_c2h_wr = 0, mc_clr_h2c_rd = 0;
  logic [7:0] host_wdata = '0, mc_wdata = '0;
  logic [7:0] ctrl_rdata = 8'hA5, mask_rdata = 8'h3C;
  logic [7:0] host_rdata, mc_rdata;
  logic ctrl_wr_sel, mask_wr_sel;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  msgbuf_pair u_msgbuf_pair (.*);

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d, input logic clr);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1; host_clr_h2c_wr = clr;
    @(negedge clk);
    host_wr = 0; host_clr_h2c_wr = 0;
  endtask

  task automatic host_read(input logic [1:0] a, input logic clr, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1; host_clr_c2h_rd = clr;
    @(negedge clk);
    host_rd = 0; host_clr_c2h_rd = 0;
    d = host_rdata;
  endtask

  task automatic mc_write(input logic [7:0] d, input logic clr);
    @(negedge clk);
    mc_wdata = d; mc_wr = 1; mc_clr_c2h_wr = clr;
    @(negedge clk);
    mc_wr = 0; mc_clr_c2h_wr = 0;
  endtask

  task automatic mc_read(input logic clr, output logic [7:0] d);
    @(negedge clk);
    mc_rd = 1; mc_clr_h2c_rd = clr;
    @(negedge clk);
    mc_rd = 0; mc_clr_h2c_rd = 0;
    d = mc_rdata;
  endtask

  task automatic clear_all;
    @(negedge clk);
    host_clr_h2c_wr = 1; host_clr_c2h_rd = 1; mc_clr_c2h_wr = 1; mc_clr_h2c_rd = 1;
    @(negedge clk);
    host_clr_h2c_wr = 0; host_clr_c2h_rd = 0; mc_clr_c2h_wr = 0; mc_clr_h2c_rd = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R9 host_rdata after reset", host_rdata, 8'h00);
    chk("R9 mc_rdata after reset", mc_rdata, 8'h00);
    mc_read(0, d);   chk("R9 h2c empty after reset", d, 8'h00);
    host_read(2'd1, 0, d); chk("R9 c2h empty after reset", d, 8'h00);
  endtask

  task automatic t_decode;
    logic [7:0] d;
    host_read(2'd0, 0, d); chk("R1 offset0 read", d, 8'hA5);
    host_read(2'd2, 0, d); chk("R1 offset2 read", d, 8'h3C);
    host_read(2'd3, 0, d); chk("R1 offset3 read", d, 8'h00);
    @(negedge clk);
    host_addr = 2'd0; host_wr = 1; #1;
    chk("R1 ctrl select", {6'd0, mask_wr_sel, ctrl_wr_sel}, 8'h01);
    host_addr = 2'd2; #1;
    chk("R1 mask select", {6'd0, mask_wr_sel, ctrl_wr_sel}, 8'h02);
    host_addr = 2'd3; host_wdata = 8'h77; #1;
    chk("R1 offset3 no select", {6'd0, mask_wr_sel, ctrl_wr_sel}, 8'h00);
    @(negedge clk);
    host_wr = 0;
    mc_read(0, d); chk("R1 offset3 write leaves h2c empty", d, 8'h00);
  endtask

  task automatic t_h2c_order;
    logic [7:0] d;
    clear_all();
    host_write(2'd1, 8'h11, 0); host_write(2'd1, 8'h22, 0); host_write(2'd1, 8'h33, 0);
    mc_read(0, d); chk("R2 h2c byte0", d, 8'h11);
    mc_read(0, d); chk("R2 h2c byte1", d, 8'h22);
    @(negedge clk);
    chk("R10 mc_rdata holds", mc_rdata, 8'h22);
    mc_read(0, d); chk("R2 h2c byte2", d, 8'h33);
    mc_read(0, d); chk("R5 h2c empty read", d, 8'h00);
    mc_read(1, d); chk("R8 clear beats read", d, 8'h00);
    mc_read(0, d); chk("R6 reread after mc clear", d, 8'h11);
    host_write(2'd1, 8'h44, 1);
    mc_read(1, d);
    mc_read(0, d); chk("R8 write with clear dropped", d, 8'h00);
    host_write(2'd1, 8'h55, 0);
    mc_read(1, d);
    mc_read(0, d); chk("R6 refill from start", d, 8'h55);
  endtask

  task automatic t_c2h_order;
    logic [7:0] d;
    clear_all();
    host_read(2'd1, 0, d); chk("R5 c2h empty read", d, 8'h00);
    mc_write(8'hC1, 0); mc_write(8'hC2, 0);
    host_read(2'd1, 0, d); chk("R5 pointer kept after empty read", d, 8'hC1);
    @(negedge clk);
    chk("R10 host_rdata holds", host_rdata, 8'hC1);
    host_read(2'd1, 0, d); chk("R3 c2h byte1", d, 8'hC2);
    host_read(2'd1, 1, d); chk("R8 host clear beats read", d, 8'h00);
    host_read(2'd1, 0, d); chk("R7 reread after host clear", d, 8'hC1);
    mc_write(8'hD0, 1);
    mc_write(8'hD1, 0);
    host_read(2'd1, 1, d);
    host_read(2'd1, 0, d); chk("R7 refill after mc clear", d, 8'hD1);
    host_read(2'd1, 0, d); chk("R8 mc write with clear dropped", d, 8'h00);
  endtask

  task automatic t_capacity;
    logic [7:0] d;
    int bad = 0;
    clear_all();
    for (int i = 0; i < 65; i++) host_write(2'd1, 8'(i + 1), 0);
    for (int i = 0; i < 64; i++) begin
      mc_read(0, d);
      if (d !== 8'(i + 1)) bad++;
    end
    chk("R4 64 bytes kept in order", 8'(bad), 8'h00);
    mc_read(0, d); chk("R4 byte 65 dropped", d, 8'h00);
    mc_read(1, d);
    mc_read(0, d); chk("R4 first byte intact after overflow", d, 8'h01);
    clear_all();
    for (int i = 0; i < 66; i++) mc_write(8'(8'h80 + i), 0);
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      host_read(2'd1, 0, d);
      if (d !== 8'(8'h80 + i)) bad++;
    end
    chk("R3 64 c2h bytes in order", 8'(bad), 8'h00);
    host_read(2'd1, 0, d); chk("R4 c2h overflow dropped", d, 8'h00);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired got timeout exp completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_h2c_order();
    t_c2h_order();
    t_capacity();
    finish_up();
  end
endmodule